// File: doc/BRIEF.md
# Runtime-Selectable Fixed-Point Activation Stage

This block turns a stream of signed 32-bit accumulator sums into 16-bit activations for the next layer of a neural network. The input is in Q15.16 format. The output is in signed Q7.8 format, the same format the weights use. A one-bit selector travels with each input beat and chooses the function for that beat. One choice is a rectifier. The other is a sigmoid approximation built from magnitude comparisons, right shifts and additions, with no stored table.

The stage accepts one beat on every clock and registers the result once. Each result appears exactly one cycle after its input beat. A producer can therefore stream a full layer of sums back to back. It can also change the function between any two beats without draining the pipe.

Top module: `act_stage`

## Requirements
- R1: `outValid` equals `inValid` from the previous clock, so each result appears exactly one cycle after its input beat.
- R2: While `rstN` is low, `outValid` is 0 and `outData` is 0x0000.
- R3: With `inSelSigmoid` = 0, an input with bit 31 set (a negative value) yields 0x0000.
- R4: With `inSelSigmoid` = 0, a non-negative input below 2^23 yields its bits [23:8]. This is the value divided by 256 and truncated toward zero.
- R5: With `inSelSigmoid` = 0, a non-negative input of 2^23 (128.0) or more saturates to 0x7FFF.
- R6: With `inSelSigmoid` = 1 and a non-negative input a, the stage first forms a Q.16 value f:
  - a < 65536 (1.0): f = floor(a/4) + 32768
  - 65536 ≤ a < 155648 (2.375): f = floor(a/8) + 40960
  - 155648 ≤ a < 327680 (5.0): f = floor(a/32) + 55296
  - a ≥ 327680: f = 65536

  The output is floor(f/256).
- R7: With `inSelSigmoid` = 1 and a negative input x, the output is floor((65536 − f(|x|))/256). This includes x = −2^31.
- R8: With `inSelSigmoid` = 1, the output always lies in 0..256 (0x0000..0x0100).
- R9: The selector is taken from the same beat as the data, so changing it affects only that beat and later ones.
- R10: A clock with `inValid` low leaves `outData` unchanged and drives `outValid` low, whatever `inData` and `inSelSigmoid` carry.
- R11: Back-to-back beats on consecutive clocks each produce their own result, with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input beat present this cycle |
| inSelSigmoid | input | 1 | Function for this beat: 0 rectifier, 1 sigmoid |
| inData | input | 32 | Signed Q15.16 accumulator sum |
| outValid | output | 1 | Result present this cycle |
| outData | output | 16 | Signed Q7.8 activation |

## Verification
The embedded properties watch, on every clock:
- the one-cycle valid delay;
- the hold of the output register on idle cycles;
- zeroing of negative rectifier inputs and saturation of large ones;
- the 0..256 range and non-negative sign of every sigmoid result.

Only the bench scenarios can show that each sigmoid segment gives the right value on both sides of its breakpoints. The same holds for the mirrored formula on negative inputs, including the most negative sum. The bench scenarios also show that a selector flip between adjacent beats takes effect on exactly the right beat.

// File: rtl/act_pkg.sv
package act_pkg;
  // Strobes handed from control to datapath for the current cycle.
  typedef struct packed {
    logic capture;     // load the output register this cycle
    logic useSigmoid;  // function for the beat being captured
  } act_strobe_t;
endpackage

// File: rtl/act_ctrl.sv
module act_ctrl
  import act_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSelSigmoid,
  output act_strobe_t stb,
  output logic        outValid
);
  logic validQ;

  always_comb begin
    stb.capture    = inValid;
    stb.useSigmoid = inSelSigmoid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign outValid = validQ;

  // R1: a beat in produces a valid out on the next clock, an idle cycle none
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/act_datapath.sv
module act_datapath
  import act_pkg::*;
#(
  parameter int IN_W     = 32,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  act_strobe_t      stb,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData
);
  localparam int SHIFT  = IN_FRAC - OUT_FRAC;
  localparam int SAT_LO = OUT_W - 1 + SHIFT;
  localparam int MW     = IN_W + 1;

  localparam logic [MW-1:0] LSB   = MW'(1);
  localparam logic [MW-1:0] ONE   = MW'(1) << IN_FRAC;
  localparam logic [MW-1:0] BP1   = ONE;
  localparam logic [MW-1:0] BP2   = (MW'(19) << IN_FRAC) >> 3;
  localparam logic [MW-1:0] BP3   = MW'(5) << IN_FRAC;
  localparam logic [MW-1:0] OFF1  = ONE >> 1;
  localparam logic [MW-1:0] OFF2  = (MW'(5) << IN_FRAC) >> 3;
  localparam logic [MW-1:0] OFF3  = (MW'(27) << IN_FRAC) >> 5;
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};

  logic             negIn;
  logic [MW-1:0]    mag, seg, sigFull, sigShift;
  logic [OUT_W-1:0] sigOut, reluOut, nextData, dataQ;

  // Sigmoid: piecewise-linear on |x|, mirrored for negative x
  always_comb begin
    negIn = inData[IN_W-1];
    mag   = negIn ? ({1'b0, ~inData} + LSB) : {1'b0, inData};
    if (mag < BP1)      seg = (mag >> 2) + OFF1;
    else if (mag < BP2) seg = (mag >> 3) + OFF2;
    else if (mag < BP3) seg = (mag >> 5) + OFF3;
    else                seg = ONE;
    sigFull  = negIn ? (ONE - seg) : seg;
    sigShift = sigFull >> SHIFT;
    sigOut   = sigShift[OUT_W-1:0];
  end

  // Rectifier with truncation and positive saturation
  always_comb begin
    if (negIn)                        reluOut = '0;
    else if (|inData[IN_W-2:SAT_LO])  reluOut = MAXV;
    else                              reluOut = {1'b0, inData[SAT_LO-1:SHIFT]};
  end

  assign nextData = stb.useSigmoid ? sigOut : reluOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataQ <= '0;
    else if (stb.capture) dataQ <= nextData;
  end

  assign outData = dataQ;

  // R10: idle cycles leave the result register untouched
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(dataQ));
endmodule

// File: rtl/act_stage.sv
module act_stage
  import act_pkg::*;
#(
  parameter int IN_W     = 32,
  parameter int IN_FRAC  = 16,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSelSigmoid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);
  localparam int SAT_LO = OUT_W - 1 + IN_FRAC - OUT_FRAC;

  act_strobe_t stb;

  act_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSelSigmoid(inSelSigmoid),
    .stb(stb), .outValid(outValid)
  );

  act_datapath #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .outData(outData)
  );

  // R3: negative rectifier input gives zero
  p_relu_neg_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inSelSigmoid && inData[IN_W-1]) |=> (outData == '0));
  // R5: large positive rectifier input saturates
  p_relu_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inSelSigmoid && !inData[IN_W-1] && (|inData[IN_W-2:SAT_LO]))
    |=> (outData == {1'b0, {(OUT_W-1){1'b1}}}));
  // R8: sigmoid result never negative and never above 1.0
  p_sig_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSelSigmoid) |=> (!outData[OUT_W-1] && (outData <= (OUT_W'(1) << OUT_FRAC))));
endmodule

// File: tb/act_stage_test.sv
module act_stage_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSelSigmoid = 1'b0;
  logic [31:0] inData = '0;
  logic        outValid;
  logic [15:0] outData;

  int checks = 0;
  int errors = 0;
  logic        expValid = 1'b0;
  logic [15:0] expData = '0;

  always #4 clk = ~clk;  // 125 MHz

  act_stage uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSelSigmoid(inSelSigmoid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  function automatic logic [15:0] refAct(logic [31:0] raw, logic sig);
    longint x, a, f, y;
    x = longint'($signed(raw));
    if (!sig) begin
      if (x < 0) return 16'h0000;
      y = x / 256;
      if (y > 32767) y = 32767;
      return 16'(y);
    end
    a = (x < 0) ? -x : x;
    if (a < 65536)       f = a / 4 + 32768;
    else if (a < 155648) f = a / 8 + 40960;
    else if (a < 327680) f = a / 32 + 55296;
    else                 f = 65536;
    if (x < 0) f = 65536 - f;
    return 16'(f / 256);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (outValid !== expValid || outData !== expData) begin
      errors++;
      $display("FAIL %s got valid=%0b data=%h expected valid=%0b data=%h",
               tag, outValid, outData, expValid, expData);
    end
  endtask

  // drive one cycle at the falling edge, check after the next rising edge
  task automatic beat(logic v, logic s, logic [31:0] d, string tag);
    inValid = v; inSelSigmoid = s; inData = d;
    expValid = v;
    if (v) expData = refAct(d, s);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R2 reset state");
    rstN = 1'b1;
    @(negedge clk);

    // rectifier
    beat(1, 0, 32'hFFFF_FFFF, "R3 relu -lsb");
    beat(1, 0, 32'h8000_0000, "R3 relu most negative");
    beat(1, 0, 32'h0000_0000, "R4 relu zero");
    beat(1, 0, 32'h0001_0000, "R4 relu 1.0");
    beat(1, 0, 32'h0001_80FF, "R4 relu truncation");
    beat(1, 0, 32'h007F_FFFF, "R4 relu just below limit");
    beat(1, 0, 32'h0080_0000, "R5 relu at limit");
    beat(1, 0, 32'h7FFF_FFFF, "R5 relu max");

    // sigmoid segments and breakpoints
    beat(1, 1, 32'h0000_0000, "R6 sig zero");
    beat(1, 1, 32'h0000_8000, "R6 sig 0.5");
    beat(1, 1, 32'h0000_FFFF, "R6 sig below 1.0");
    beat(1, 1, 32'h0001_0000, "R6 sig at 1.0");
    beat(1, 1, 32'd155647,    "R6 sig below 2.375");
    beat(1, 1, 32'd155648,    "R6 sig at 2.375");
    beat(1, 1, 32'd327679,    "R6 sig below 5.0");
    beat(1, 1, 32'd327680,    "R6 sig at 5.0");
    beat(1, 1, 32'h7FFF_FFFF, "R6 sig max");
    beat(1, 1, 32'hFFFF_0000, "R7 sig -1.0");
    beat(1, 1, 32'hFFFF_FFFF, "R7 sig -lsb");
    beat(1, 1, -32'sd200000,  "R7 sig -3.05");
    beat(1, 1, 32'h8000_0000, "R8 sig most negative");

    // idle cycles with junk on the inputs
    beat(0, 1, 32'h8000_0000, "R10 idle hold a");
    beat(0, 0, 32'h7FFF_FFFF, "R10 idle hold b");

    // selector flips on adjacent beats
    beat(1, 0, 32'hFFFF_0000, "R9 relu beat before flip");
    beat(1, 1, 32'hFFFF_0000, "R9 sig beat after flip");
    beat(1, 0, 32'h0002_0000, "R9 relu beat after flip back");
    beat(1, 1, 32'h0002_0000, "R9 sig same data");

    // sustained random stream, valid and selector varying
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (i % 3 == 0) d = {{12{d[31]}}, d[19:0]};
      beat((i % 7) != 6, 1'($urandom), d, "R11 stream");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule